// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a simple 8-bit register bus and a byte-level I2C transaction agent. Software programs five registers: an own-address register, a clock divider, a control register, a status register and a data register. Writes and reads of the data register are turned into transaction requests on a single-cycle port. The agent answers in the same cycle. A start carries a 7-bit target address and a direction bit. A send carries a byte. A receive returns a byte. A stop closes the transfer.

The block tracks whether a transfer is open. When no transfer is open, the first data write is taken as the address byte. The status register records the last acknowledge result, the bus-busy state and a pending-interrupt flag, and that flag drives the interrupt output. Clearing the enable bit performs a soft reset. The agent generates the SCL/SDA bit timing itself. When a send is NACKed, the agent closes that transfer by itself.

Register offsets are 0x00 own address, 0x04 divider, 0x08 control, 0x0C status and 0x10 data. Control bits: enable bit 7, interrupt-enable bit 6, master-select bit 5, transmit bit 4, repeated-start bit 2. Status bits: bus-busy bit 5, arbitration-lost bit 4, interrupt-flag bit 1, receive-NACK bit 0. Transaction opcodes are START=0, SEND=1, RECV=2 and STOP=3.

Top module: `i2cm_regblk`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low and no transaction is requested.
- R2: Writes are masked per register: own address keeps bits 7:1 (mask 0xFE), divider keeps bits 5:0 (0x3F), control keeps bits 7:2 (0xFC). An offset outside the five registers reads 0x00, and a write to it changes nothing.
- R3: When enable (control bit 7) is set, a control write with bit 7 clear zeroes every register except own address. It also closes the open transfer, if any, and a STOP (op 3) is requested in that same cycle.
- R4: Any other control write stores the masked value. Bus-busy (status bit 5) then equals master-select (bit 5). If master-select is clear and a transfer is open, a STOP is requested and the block returns to idle.
- R5: A control write with repeated-start (bit 2) set while a transfer is open requests a STOP, returns the block to idle and leaves bit 2 reading 0. With no open transfer, bit 2 is stored as written.
- R6: A data write while enable is clear requests no transaction.
- R7: With the block enabled and in master mode and no open transfer, a data write requests START (op 0) with the written byte (address in bits 7:1, direction in bit 0). A NACK sets status bit 0 and the block stays idle. An ACK clears bit 0, opens the transfer and raises the interrupt.
- R8: With a transfer open, a data write requests SEND (op 1) with the byte. An ACK clears status bit 0 and raises the interrupt. A NACK sets status bit 0 and closes the transfer, so the next data write is again a START.
- R9: A data read returns the byte latched before that read. In master mode with a transfer open and transmit clear, it requests RECV (op 2). A good fetch latches the returned byte and raises the interrupt, and a failed fetch latches 0xFF. In master mode with no open transfer or with transmit set, the read latches 0xFF and requests nothing.
- R10: Raising the interrupt sets status bit 1 and drives `irq` high, but only while enable and interrupt-enable are both set.
- R11: Writing 0 to status bit 1 while it is set clears it and drops `irq`. Writing 0 to bit 4 clears it. Writing 1 to any status bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt, mirrors the interrupt flag |
| xact_req | output | 1 | Transaction request this cycle |
| xact_op | output | 2 | Opcode: 0 START, 1 SEND, 2 RECV, 3 STOP |
| xact_byte | output | 8 | Address or data byte for START/SEND, else 0 |
| xact_ack | input | 1 | Agent answer to START/SEND: 1 = ACK |
| xact_rx_ok | input | 1 | Agent answer to RECV: 1 = byte valid |
| xact_rx_byte | input | 8 | Byte returned for RECV |

## Verification
A scripted session runs a whole transfer. It includes an address NACK followed by an ACK, sends with ACK and NACK, and receives that succeed and that fail. This separates the start-versus-send choice, which depends only on whether a transfer is open, from the acknowledge handling. Restarts and master-select drops in the middle of a transfer show that the block closes the transfer and returns to idle. Directed cases set the control bits in patterns that separate enable, interrupt-enable and master mode. They also check that a soft reset keeps the own-address register and clears everything else.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 5;
    localparam int STRIDE  = 4;

    localparam int IDX_OWN  = 0;
    localparam int IDX_DIV  = 1;
    localparam int IDX_CTRL = 2;
    localparam int IDX_STAT = 3;
    localparam int IDX_DATA = 4;

    localparam logic [DW-1:0] MASK_OWN  = 8'hFE;
    localparam logic [DW-1:0] MASK_DIV  = 8'h3F;
    localparam logic [DW-1:0] MASK_CTRL = 8'hFC;

    localparam int C_EN = 7;
    localparam int C_IE = 6;
    localparam int C_MS = 5;
    localparam int C_TX = 4;
    localparam int C_RS = 2;

    localparam int S_BB = 5;
    localparam int S_AL = 4;
    localparam int S_IF = 1;
    localparam int S_NK = 0;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } xop_e;

    typedef struct packed {
        logic [DW-1:0] own;
        logic [DW-1:0] div;
        logic [DW-1:0] ctrl;
        logic          busy;
        logic          lost;
        logic          iflag;
        logic          nack;
        logic [DW-1:0] rx;
        logic          active;
    } state_t;
endpackage

// File: rtl/i2cm_regdec.sv
module i2cm_regdec #(
    parameter int AW     = 5,
    parameter int NREG   = 5,
    parameter int STRIDE = 4
) (
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (addr == AW'(i * STRIDE));
    end
endmodule

// File: rtl/i2cm_rdmux.sv
module i2cm_rdmux #(
    parameter int DW   = 8,
    parameter int NREG = 5
) (
    input  logic [NREG-1:0]         hit,
    input  logic [NREG-1:0][DW-1:0] vals,
    output logic [DW-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            rdata = rdata | (vals[i] & {DW{hit[i]}});
        end
    end
endmodule

// File: rtl/i2cm_regblk.sv
module i2cm_regblk
    import i2cm_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          xact_req,
    output logic [1:0]    xact_op,
    output logic [DW-1:0] xact_byte,
    input  logic          xact_ack,
    input  logic          xact_rx_ok,
    input  logic [DW-1:0] xact_rx_byte
);
    state_t s_d, s_q;
    logic [NREG-1:0] hit;
    logic [NREG-1:0][DW-1:0] vals;
    logic wr_acc, rd_acc, en, master, raise_ok, act_d;
    xop_e op_d;

    i2cm_regdec #(.AW(AW), .NREG(NREG), .STRIDE(STRIDE)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    always_comb begin
        vals           = '0;
        vals[IDX_OWN]  = s_q.own;
        vals[IDX_DIV]  = s_q.div;
        vals[IDX_CTRL] = s_q.ctrl;
        vals[IDX_STAT] = {2'b00, s_q.busy, s_q.lost, 2'b00, s_q.iflag, s_q.nack};
        vals[IDX_DATA] = s_q.rx;
    end

    i2cm_rdmux #(.DW(DW), .NREG(NREG)) u_rd (
        .hit   (hit),
        .vals  (vals),
        .rdata (reg_rdata)
    );

    assign wr_acc   = reg_sel & reg_wr;
    assign rd_acc   = reg_sel & ~reg_wr;
    assign en       = s_q.ctrl[C_EN];
    assign master   = s_q.ctrl[C_MS];
    assign raise_ok = s_q.ctrl[C_EN] & s_q.ctrl[C_IE];

    always_comb begin
        s_d       = s_q;
        xact_req  = 1'b0;
        op_d      = OP_STOP;
        xact_byte = '0;
        act_d     = s_q.active;

        if (wr_acc && hit[IDX_OWN]) s_d.own = reg_wdata & MASK_OWN;
        if (wr_acc && hit[IDX_DIV]) s_d.div = reg_wdata & MASK_DIV;

        if (wr_acc && hit[IDX_CTRL]) begin
            if (en && !reg_wdata[C_EN]) begin
                if (s_q.active) xact_req = 1'b1;
                s_d     = '0;
                s_d.own = s_q.own;
                act_d   = 1'b0;
            end else begin
                s_d.ctrl = reg_wdata & MASK_CTRL;
                if (reg_wdata[C_MS]) begin
                    s_d.busy = 1'b1;
                end else begin
                    s_d.busy = 1'b0;
                    if (act_d) begin
                        xact_req = 1'b1;
                        act_d    = 1'b0;
                    end
                end
                if (reg_wdata[C_RS] && act_d) begin
                    xact_req         = 1'b1;
                    act_d            = 1'b0;
                    s_d.ctrl[C_RS]   = 1'b0;
                end
                s_d.active = act_d;
            end
        end

        if (wr_acc && hit[IDX_STAT]) begin
            if (s_q.iflag && !reg_wdata[S_IF]) s_d.iflag = 1'b0;
            if (s_q.lost && !reg_wdata[S_AL])  s_d.lost  = 1'b0;
        end

        if (wr_acc && hit[IDX_DATA] && en && master) begin
            xact_req  = 1'b1;
            xact_byte = reg_wdata;
            if (!s_q.active) begin
                op_d = OP_START;
                if (xact_ack) begin
                    s_d.active = 1'b1;
                    s_d.nack   = 1'b0;
                    if (raise_ok) s_d.iflag = 1'b1;
                end else begin
                    s_d.nack = 1'b1;
                end
            end else begin
                op_d = OP_SEND;
                if (xact_ack) begin
                    s_d.nack = 1'b0;
                    if (raise_ok) s_d.iflag = 1'b1;
                end else begin
                    s_d.nack   = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end

        if (rd_acc && hit[IDX_DATA] && master) begin
            if (s_q.active && !s_q.ctrl[C_TX]) begin
                xact_req = 1'b1;
                op_d     = OP_RECV;
                if (xact_rx_ok) begin
                    s_d.rx = xact_rx_byte;
                    if (raise_ok) s_d.iflag = 1'b1;
                end else begin
                    s_d.rx = 8'hFF;
                end
            end else begin
                s_d.rx = 8'hFF;
            end
        end
    end

    assign xact_op = op_d;
    assign irq     = s_q.iflag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Interrupt only rises while both enables were set (R10)
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(s_q.ctrl[C_EN] && s_q.ctrl[C_IE]));

    // Data write while disabled stays off the transaction port (R6)
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_DATA] && !s_q.ctrl[C_EN]) |-> !xact_req);

    // Bus-busy drops after a control write without master-select (R4)
    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_CTRL] && !reg_wdata[C_MS]) |=> !s_q.busy);

    // A NACKed send leaves the block idle (R8)
    assert_nack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_req && xact_op == OP_SEND && !xact_ack) |=> !s_q.active);

    // Interrupt flag falls only on a zero write or a soft reset (R11)
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.iflag) |-> $past(wr_acc && ((hit[IDX_STAT] && !reg_wdata[S_IF]) ||
                                               (hit[IDX_CTRL] && !reg_wdata[C_EN]))));

    // Soft reset keeps the own-address register (R3)
    assert_own_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_CTRL] && s_q.ctrl[C_EN] && !reg_wdata[C_EN]) |=> $stable(s_q.own));
endmodule

// File: tb/tb_i2cm_regblk.sv
`timescale 1ns/1ps
module tb_i2cm_regblk;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, xact_req;
    logic [1:0] xact_op;
    logic [7:0] xact_byte;
    logic xact_ack = 1'b0, xact_rx_ok = 1'b0;
    logic [7:0] xact_rx_byte = '0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    i2cm_regblk dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .xact_req(xact_req), .xact_op(xact_op), .xact_byte(xact_byte),
        .xact_ack(xact_ack), .xact_rx_ok(xact_rx_ok), .xact_rx_byte(xact_rx_byte)
    );

    typedef struct packed {
        logic       wr;
        logic [4:0] addr;
        logic [7:0] wd;
        logic       ack;
        logic       rxok;
        logic [7:0] rxb;
        logic       req;
        logic [1:0] op;
        logic [7:0] xb;
        logic [7:0] rd;
        logic       irq;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h08, 8'hC0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b1, 5'h10, 8'h55, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd7},  // R7 slave: no req
        '{1'b1, 5'h08, 8'hF0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b0, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h20, 1'b0, 4'd4},  // R4 busy
        '{1'b1, 5'h10, 8'hA4, 1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 8'hA4, 8'h00, 1'b0, 4'd7},  // R7 nack
        '{1'b0, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h21, 1'b0, 4'd7},
        '{1'b1, 5'h10, 8'hA4, 1'b1, 1'b0, 8'h00, 1'b1, 2'd0, 8'hA4, 8'h00, 1'b1, 4'd7},  // R7 ack
        '{1'b0, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h22, 1'b1, 4'd7},
        '{1'b1, 5'h0C, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b1, 4'd11}, // R11 write 1
        '{1'b1, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd11}, // R11 clear
        '{1'b1, 5'h10, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b1, 2'd1, 8'h3C, 8'h00, 1'b1, 4'd8},  // R8 send ack
        '{1'b1, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd11},
        '{1'b1, 5'h08, 8'hE0, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd4},
        '{1'b0, 5'h10, 8'h00, 1'b0, 1'b1, 8'h9E, 1'b1, 2'd2, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 recv ok
        '{1'b0, 5'h10, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 8'h00, 8'h9E, 1'b1, 4'd9},  // R9 recv fail
        '{1'b0, 5'h10, 8'h00, 1'b0, 1'b1, 8'h11, 1'b1, 2'd2, 8'h00, 8'hFF, 1'b1, 4'd9},
        '{1'b1, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd11},
        '{1'b1, 5'h08, 8'hE4, 1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 8'h00, 8'h00, 1'b0, 4'd5},  // R5 restart
        '{1'b0, 5'h08, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'hE0, 1'b0, 4'd5},
        '{1'b0, 5'h10, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 2'd0, 8'h00, 8'h11, 1'b0, 4'd9},  // R9 idle read
        '{1'b0, 5'h10, 8'h00, 1'b0, 1'b1, 8'h77, 1'b0, 2'd0, 8'h00, 8'hFF, 1'b0, 4'd9},
        '{1'b1, 5'h10, 8'h7A, 1'b1, 1'b0, 8'h00, 1'b1, 2'd0, 8'h7A, 8'h00, 1'b1, 4'd7},
        '{1'b1, 5'h10, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 8'h01, 8'h00, 1'b1, 4'd8},  // R8 send nack
        '{1'b1, 5'h10, 8'h02, 1'b1, 1'b0, 8'h00, 1'b1, 2'd0, 8'h02, 8'h00, 1'b1, 4'd8},  // R8 back to start
        '{1'b1, 5'h08, 8'hC0, 1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 8'h00, 8'h00, 1'b1, 4'd4},  // R4 drop master
        '{1'b0, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h02, 1'b1, 4'd4},
        '{1'b1, 5'h08, 8'h04, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 soft reset
        '{1'b0, 5'h08, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd3},
        '{1'b0, 5'h0C, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 4'd3}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [4:0] a, input logic [7:0] d,
                         input logic k, input logic ok, input logic [7:0] rb);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = w; reg_addr = a; reg_wdata = d;
        xact_ack = k; xact_rx_ok = ok; xact_rx_byte = rb;
        #1;
    endtask

    task automatic close_cyc();
        @(posedge clk);
        #1;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0, 8'h00);
        close_cyc();
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        drive(1'b0, a, 8'h00, 1'b0, 1'b0, 8'h00);
        chk(tag, reg_rdata, exp);
        close_cyc();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 req", {7'd0, xact_req}, 8'h00);
        for (int a = 0; a < 5; a++) rd_chk("R1 reg", 5'(a * 4), 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d step%0d", v.rq, i);
            drive(v.wr, v.addr, v.wd, v.ack, v.rxok, v.rxb);
            chk({tg, " req"}, {7'd0, xact_req}, {7'd0, v.req});
            if (v.req) begin
                chk({tg, " op"}, {6'd0, xact_op}, {6'd0, v.op});
                chk({tg, " byte"}, xact_byte, v.xb);
            end
            if (!v.wr) chk({tg, " rdata"}, reg_rdata, v.rd);
            close_cyc();
            chk({tg, " irq"}, {7'd0, irq}, {7'd0, v.irq});
        end

        // R2 masks and unmapped offset
        wr_reg(5'h00, 8'hFF); rd_chk("R2 own", 5'h00, 8'hFE);
        wr_reg(5'h04, 8'hFF); rd_chk("R2 div", 5'h04, 8'h3F);
        wr_reg(5'h14, 8'hFF); rd_chk("R2 unmapped", 5'h14, 8'h00);
        wr_reg(5'h08, 8'h03); rd_chk("R2 ctrl", 5'h08, 8'h00);

        // R6 disabled master: data write ignored
        wr_reg(5'h08, 8'h30);
        drive(1'b1, 5'h10, 8'h42, 1'b1, 1'b0, 8'h00);
        chk("R6 req", {7'd0, xact_req}, 8'h00);
        close_cyc();
        rd_chk("R6 stat", 5'h0C, 8'h20);

        // R10 enabled without interrupt-enable
        wr_reg(5'h08, 8'hB0);
        drive(1'b1, 5'h10, 8'h42, 1'b1, 1'b0, 8'h00);
        chk("R10 start", {7'd0, xact_req}, 8'h01);
        close_cyc();
        chk("R10 irq", {7'd0, irq}, 8'h00);
        rd_chk("R10 stat", 5'h0C, 8'h20);

        // R3 soft reset with open transfer
        drive(1'b1, 5'h08, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R3 stop req", {7'd0, xact_req}, 8'h01);
        chk("R3 stop op", {6'd0, xact_op}, 8'h03);
        close_cyc();
        rd_chk("R3 own kept", 5'h00, 8'hFE);
        rd_chk("R3 div clr", 5'h04, 8'h00);
        rd_chk("R3 stat clr", 5'h0C, 8'h00);
        wr_reg(5'h08, 8'hB0);
        drive(1'b1, 5'h10, 8'h50, 1'b1, 1'b0, 8'h00);
        chk("R3 idle start", {6'd0, xact_op}, 8'h00);
        close_cyc();

        // R4 master drop ends transfer, then R5 restart with no transfer is kept
        drive(1'b1, 5'h08, 8'h80, 1'b0, 1'b0, 8'h00);
        chk("R4 stop", {7'd0, xact_req}, 8'h01);
        close_cyc();
        rd_chk("R4 busy clr", 5'h0C, 8'h00);
        drive(1'b1, 5'h08, 8'h84, 1'b0, 1'b0, 8'h00);
        chk("R5 no req", {7'd0, xact_req}, 8'h00);
        close_cyc();
        rd_chk("R5 kept", 5'h08, 8'h84);

        report();
    end
endmodule